// File: doc/BRIEF.md
# Block Transfer Byte Sequencer

This block streams the data phase of a card data command. It sits between a 16-bit word FIFO and a byte-wide card data path. In the receive direction it takes bytes from the card, pairs them into words and pushes them into the FIFO. In the transmit direction it pops words from the FIFO and hands their bytes to the card, low byte first. It moves at most one byte per clock.

Two down-counters track progress. One counts the bytes left in the current block and the other counts the blocks left in the transfer. When a block holds an odd number of bytes, its last word carries a single byte. The counters reload themselves at each block end and at the transfer end, so a repeated transfer with the same geometry needs no new programming. The host sees both counters live on output ports.

A start pulse marks each command. A data-type command clears the FIFO, latches the direction and arms the sequencer. Any other command halts it. When the final byte of the final block moves, the sequencer drops its active flag and pulses a done flag.

Top module: `bseq_top`

## Requirements
- R1: Writing the length register with value L loads both the programmed block length and the live byte counter with L+1 on the next clock.
- R2: Writing the count register with value C loads the programmed block count and the live block counter with C+1. In the same clock it reloads the byte counter from the programmed block length.
- R3: Packing order: bits 7:0 of a FIFO word carry the earlier byte and bits 15:8 carry the later byte. On receive a word is pushed once its second byte arrives. On transmit the popped word's low byte is sent first, then its high byte.
- R4: A block ends on a word boundary. If a block's last byte is the first byte of a word, on receive that word is pushed with bits 15:8 equal to zero. On transmit the word's high byte is discarded, and the next block starts with a fresh word.
- R5: In receive, a new word is not begun while the FIFO fill count is greater than the almost-full level, so no byte is accepted. In transmit, no byte is offered while the FIFO is empty and no word is half sent. The FIFO is never popped while empty.
- R6: Each byte moved decrements the byte counter by one. When the byte counter is at 1 and a byte moves, the byte counter reloads from the block length and the block counter decrements.
- R7: When the final byte of the final block moves, the block counter reloads from the block count and the active flag clears on that clock edge. The done output is high for exactly the following cycle.
- R8: A start pulse of data type asserts the FIFO clear output in that same cycle, sets the active flag and latches the direction (start_rx=1 receive, 0 transmit). A start pulse of non-data type clears the active flag, and no byte moves after it. After reset the block is idle with both counters at zero.
- R9: The byte_left and blk_left outputs show the live down-counters at every cycle.
- R10: At most one byte moves per clock, and the FIFO is never pushed and popped in the same cycle. While the card handshake stalls, both counters and the FIFO stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_len_we | input | 1 | Length register write strobe |
| blk_len_val | input | LEN_W | Block length minus one |
| blk_cnt_we | input | 1 | Count register write strobe |
| blk_cnt_val | input | LEN_W | Block count minus one |
| start | input | 1 | Command start pulse |
| start_data | input | 1 | Command is a data command |
| start_rx | input | 1 | Data direction: 1 receive, 0 transmit |
| af_level | input | LVL_W | FIFO almost-full level |
| fifo_fill | input | LVL_W+1 | FIFO fill count in words |
| fifo_rdata | input | 16 | FIFO head word |
| fifo_pop | output | 1 | Remove the head word |
| fifo_push | output | 1 | Append fifo_wdata |
| fifo_wdata | output | 16 | Word to append |
| fifo_clear | output | 1 | Reset FIFO pointers |
| tx_valid | output | 1 | Byte offered to the card |
| tx_byte | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the byte |
| rx_valid | input | 1 | Card offers a byte |
| rx_byte | input | 8 | Byte from the card |
| rx_ready | output | 1 | Sequencer takes the byte |
| byte_left | output | LEN_W+1 | Live byte counter |
| blk_left | output | LEN_W+1 | Live block counter |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A wrong half-word state shows up at the very next push as a byte-swapped word, or as a non-zero upper byte after an odd block. On transmit it shows up as a duplicated or skipped byte on the card side within one cycle. A counter that slips shows up at once on byte_left or blk_left. It also moves the block boundary, so a later word is packed wrongly or the done pulse arrives a cycle early or late. A broken pause rule shows up as a byte accepted while the fill count is above the level, or as a pop issued while the FIFO is empty.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        logic active;
        dir_e dir;
    } xfer_st_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/bseq_counters.sv
module bseq_counters #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_val,
    input  logic             cnt_we,
    input  logic [LEN_W-1:0] cnt_val,
    input  logic             step,
    output logic [LEN_W:0]   byte_left,
    output logic [LEN_W:0]   blk_left,
    output logic             last_byte,
    output logic             last_blk
);
    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] blen_q, nblk_q, bcnt_q, kcnt_q;
    logic [CNT_W-1:0] len_plus, cnt_plus;

    assign len_plus  = {1'b0, len_val} + CNT_W'(1);
    assign cnt_plus  = {1'b0, cnt_val} + CNT_W'(1);
    assign last_byte = (bcnt_q == CNT_W'(1));
    assign last_blk  = (kcnt_q == CNT_W'(1));
    assign byte_left = bcnt_q;
    assign blk_left  = kcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blen_q <= '0;
            nblk_q <= '0;
            bcnt_q <= '0;
            kcnt_q <= '0;
        end else begin
            if (len_we) begin
                blen_q <= len_plus;
                bcnt_q <= len_plus;
            end
            if (cnt_we) begin
                nblk_q <= cnt_plus;
                kcnt_q <= cnt_plus;
                bcnt_q <= len_we ? len_plus : blen_q;
            end
            if (!len_we && !cnt_we && step) begin
                if (last_byte) begin
                    bcnt_q <= blen_q;
                    kcnt_q <= last_blk ? nblk_q : kcnt_q - CNT_W'(1);
                end else begin
                    bcnt_q <= bcnt_q - CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/bseq_rx_pack.sv
module bseq_rx_pack
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              last_byte,
    output logic              push,
    output logic [WORD_W-1:0] wdata,
    output logic              half
);
    logic              half_q;
    logic [BYTE_W-1:0] lo_q;

    assign half  = half_q;
    assign push  = accept && (half_q || last_byte);
    assign wdata = half_q ? pack_word(byte_in, lo_q) : pack_word('0, byte_in);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            half_q <= 1'b0;
            lo_q   <= '0;
        end else if (accept) begin
            if (half_q || last_byte) begin
                half_q <= 1'b0;
            end else begin
                half_q <= 1'b1;
                lo_q   <= byte_in;
            end
        end
    end

endmodule

// File: rtl/bseq_tx_unpack.sv
module bseq_tx_unpack
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  logic [WORD_W-1:0] rdata,
    input  logic              last_byte,
    output logic              pop,
    output logic [BYTE_W-1:0] byte_out,
    output logic              half
);
    logic              half_q;
    logic [BYTE_W-1:0] hi_q;

    assign half     = half_q;
    assign pop      = accept && !half_q;
    assign byte_out = half_q ? hi_q : rdata[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            half_q <= 1'b0;
            hi_q   <= '0;
        end else if (accept) begin
            if (half_q) begin
                half_q <= 1'b0;
            end else if (!last_byte) begin
                half_q <= 1'b1;
                hi_q   <= rdata[WORD_W-1:BYTE_W];
            end
        end
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_len_we,
    input  logic [LEN_W-1:0] blk_len_val,
    input  logic             blk_cnt_we,
    input  logic [LEN_W-1:0] blk_cnt_val,
    input  logic             start,
    input  logic             start_data,
    input  logic             start_rx,
    input  logic [LVL_W-1:0] af_level,
    input  logic [LVL_W:0]   fifo_fill,
    input  logic [15:0]      fifo_rdata,
    output logic             fifo_pop,
    output logic             fifo_push,
    output logic [15:0]      fifo_wdata,
    output logic             fifo_clear,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic [LEN_W:0]   byte_left,
    output logic [LEN_W:0]   blk_left,
    output logic             xfer_active,
    output logic             xfer_done
);
    xfer_st_t st_q;
    logic     done_q;
    logic     can_run, rx_half, tx_half, rx_acc, tx_acc, step;
    logic     last_byte, last_blk, final_byte;

    assign fifo_clear  = start && start_data;
    assign can_run     = st_q.active && !start && !blk_len_we && !blk_cnt_we;
    assign rx_ready    = can_run && (st_q.dir == DIR_RX)
                         && (rx_half || (fifo_fill <= {1'b0, af_level}));
    assign tx_valid    = can_run && (st_q.dir == DIR_TX)
                         && (tx_half || (fifo_fill != '0));
    assign rx_acc      = rx_valid && rx_ready;
    assign tx_acc      = tx_valid && tx_ready;
    assign step        = rx_acc || tx_acc;
    assign final_byte  = step && last_byte && last_blk;
    assign xfer_active = st_q.active;
    assign xfer_done   = done_q;

    bseq_counters #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .len_we   (blk_len_we),
        .len_val  (blk_len_val),
        .cnt_we   (blk_cnt_we),
        .cnt_val  (blk_cnt_val),
        .step     (step),
        .byte_left(byte_left),
        .blk_left (blk_left),
        .last_byte(last_byte),
        .last_blk (last_blk)
    );

    bseq_rx_pack u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .accept   (rx_acc),
        .byte_in  (rx_byte),
        .last_byte(last_byte),
        .push     (fifo_push),
        .wdata    (fifo_wdata),
        .half     (rx_half)
    );

    bseq_tx_unpack u_tx (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .accept   (tx_acc),
        .rdata    (fifo_rdata),
        .last_byte(last_byte),
        .pop      (fifo_pop),
        .byte_out (tx_byte),
        .half     (tx_half)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= final_byte;
            if (start) begin
                st_q.active <= start_data;
                if (start_data) st_q.dir <= dir_e'(start_rx);
            end else if (final_byte) begin
                st_q.active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int LEN_W = 11,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             blk_len_we,
    input logic [LEN_W-1:0] blk_len_val,
    input logic             blk_cnt_we,
    input logic [LEN_W-1:0] blk_cnt_val,
    input logic             start,
    input logic             start_data,
    input logic [LVL_W-1:0] af_level,
    input logic [LVL_W:0]   fifo_fill,
    input logic             fifo_pop,
    input logic             fifo_push,
    input logic [15:0]      fifo_wdata,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [LEN_W:0]   byte_left,
    input logic [LEN_W:0]   blk_left,
    input logic             xfer_active,
    input logic             xfer_done,
    input logic             rx_half,
    input logic             step,
    input logic             last_byte,
    input logic             last_blk
);
    localparam int CNT_W = LEN_W + 1;

    p_len_load_r1: assert property (@(posedge clk) disable iff (rst)
        blk_len_we |=> byte_left == ({1'b0, $past(blk_len_val)} + CNT_W'(1)));

    p_cnt_load_r2: assert property (@(posedge clk) disable iff (rst)
        blk_cnt_we |=> blk_left == ({1'b0, $past(blk_cnt_val)} + CNT_W'(1)));

    p_odd_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && !rx_half) |-> fifo_wdata[15:8] == 8'h00);

    p_rx_pause_r5: assert property (@(posedge clk) disable iff (rst)
        (!rx_half && fifo_fill > {1'b0, af_level}) |-> !rx_ready);

    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_fill != '0);

    p_byte_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !last_byte) |=> byte_left == ($past(byte_left) - CNT_W'(1)));

    p_final_r7: assert property (@(posedge clk) disable iff (rst)
        (step && last_byte && last_blk) |=> (xfer_done && !xfer_active));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !xfer_active);

    p_start_data_r8: assert property (@(posedge clk) disable iff (rst)
        (start && start_data) |=> xfer_active);

    p_start_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !start_data) |=> !xfer_active);

    p_one_side_r10: assert property (@(posedge clk) disable iff (rst)
        !(fifo_push && fifo_pop) && !(rx_ready && tx_valid));

    p_tx_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> ($stable(byte_left) && $stable(blk_left)));

    p_rx_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rx_valid) |=> ($stable(byte_left) && $stable(blk_left)));

endmodule

bind bseq_top bseq_checker #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .blk_len_we (blk_len_we),
    .blk_len_val(blk_len_val),
    .blk_cnt_we (blk_cnt_we),
    .blk_cnt_val(blk_cnt_val),
    .start      (start),
    .start_data (start_data),
    .af_level   (af_level),
    .fifo_fill  (fifo_fill),
    .fifo_pop   (fifo_pop),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .byte_left  (byte_left),
    .blk_left   (blk_left),
    .xfer_active(xfer_active),
    .xfer_done  (xfer_done),
    .rx_half    (rx_half),
    .step       (step),
    .last_byte  (last_byte),
    .last_blk   (last_blk)
);

// File: tb/tb_bseq_top.sv
module tb_bseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 11;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blk_len_we = 1'b0, blk_cnt_we = 1'b0;
    logic [LEN_W-1:0] blk_len_val = '0, blk_cnt_val = '0;
    logic start = 1'b0, start_data = 1'b0, start_rx = 1'b0;
    logic [LVL_W-1:0] af_level = 5'd31;
    logic [LVL_W:0] fifo_fill = '0;
    logic [15:0] fifo_rdata = '0;
    logic fifo_pop, fifo_push, fifo_clear, tx_valid, rx_ready, xfer_active, xfer_done;
    logic [15:0] fifo_wdata;
    logic [7:0] tx_byte;
    logic tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [LEN_W:0] byte_left, blk_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    bseq_top #(.LEN_W(LEN_W), .LVL_W(LVL_W)) dut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, clear_cnt = 0;
    bit finished = 0;
    bit rx_en = 0, rx_gap = 0, tx_en = 0, host_drain = 0;
    string sb_tag = "R3";
    logic [15:0] mq[$];     // FIFO model
    logic [15:0] exp_w[$];  // expected pushed words
    logic [7:0]  exp_b[$];  // expected transmitted bytes
    logic [7:0]  src[$];    // card receive source

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver and monitor for one clock: drive at negedge, observe what the next edge commits.
    task automatic tick();
        fifo_fill  = 6'(mq.size());
        fifo_rdata = (mq.size() > 0) ? mq[0] : 16'h0000;
        rx_valid   = rx_en && (src.size() > 0) && !(rx_gap && (cyc % 3 == 2));
        rx_byte    = (src.size() > 0) ? src[0] : 8'h00;
        tx_ready   = tx_en;
        #1;
        if (xfer_done) done_cnt++;
        if (fifo_clear) begin mq.delete(); clear_cnt++; end
        if (fifo_push) begin
            if (exp_w.size() == 0) chk({sb_tag, " unexpected push"}, fifo_wdata, 0);
            else chk({sb_tag, " pushed word"}, fifo_wdata, exp_w.pop_front());
            mq.push_back(fifo_wdata);
        end
        if (fifo_pop) void'(mq.pop_front());
        if (tx_valid && tx_ready) begin
            if (exp_b.size() == 0) chk({sb_tag, " unexpected tx byte"}, tx_byte, 0);
            else chk({sb_tag, " tx byte"}, tx_byte, exp_b.pop_front());
        end
        if (rx_valid && rx_ready) void'(src.pop_front());
        if (host_drain && !fifo_push && mq.size() > 0) void'(mq.pop_front());
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr_len(int v);
        blk_len_we = 1'b1; blk_len_val = LEN_W'(v);
        tick();
        blk_len_we = 1'b0;
    endtask

    task automatic wr_cnt(int v);
        blk_cnt_we = 1'b1; blk_cnt_val = LEN_W'(v);
        tick();
        blk_cnt_we = 1'b0;
    endtask

    task automatic kick(bit data, bit rx);
        start = 1'b1; start_data = data; start_rx = rx;
        tick();
        start = 1'b0; start_data = 1'b0;
    endtask

    task automatic run_out(string tag);
        int guard = 0;
        while (xfer_active && guard < 400) begin tick(); guard++; end
        chk({tag, " transfer finished"}, int'(guard < 400), 1);
        tick();
    endtask

    // expected words for nblk blocks of blen bytes, bytes counted from b0
    task automatic gen_rx(int blen, int nblk, int b0);
        int b = b0;
        for (int k = 0; k < nblk; k++) begin
            for (int i = 0; i < blen; i += 2) begin
                src.push_back(8'(b));
                if (i + 1 < blen) begin
                    src.push_back(8'(b + 1));
                    exp_w.push_back({8'(b + 1), 8'(b)});
                    b += 2;
                end else begin
                    exp_w.push_back({8'h00, 8'(b)});
                    b += 1;
                end
            end
        end
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // Reset state (R8, R9)
        chk("R9 reset byte_left", byte_left, 0);
        chk("R9 reset blk_left", blk_left, 0);
        chk("R8 reset idle", xfer_active, 0);
        chk("R8 reset no offer", int'(tx_valid || rx_ready), 0);

        // Programming (R1, R2)
        wr_len(3);
        chk("R1 byte_left after length write", byte_left, 4);
        wr_cnt(1);
        chk("R2 blk_left after count write", blk_left, 2);
        chk("R2 byte_left reload", byte_left, 4);

        // Even receive, 2 blocks x 4 bytes, with source gaps (R3, R7, R8)
        sb_tag = "R3";
        kick(1'b1, 1'b1);
        chk("R8 fifo_clear on data start", clear_cnt, 1);
        chk("R8 active after data start", xfer_active, 1);
        gen_rx(4, 2, 8'h10);
        rx_en = 1; rx_gap = 1;
        run_out("R3");
        chk("R3 all words pushed", exp_w.size(), 0);
        chk("R3 fifo holds words", mq.size(), 4);
        chk("R7 one done pulse", done_cnt, 1);
        chk("R7 blk_left reloaded", blk_left, 2);
        chk("R7 byte_left reloaded", byte_left, 4);
        chk("R7 idle at end", xfer_active, 0);

        // Odd receive, 2 blocks x 3 bytes (R4)
        sb_tag = "R4";
        wr_len(2);
        wr_cnt(1);
        kick(1'b1, 1'b1);
        chk("R8 fifo cleared again", clear_cnt, 2);
        gen_rx(3, 2, 8'h21);
        run_out("R4");
        chk("R4 odd words pushed", exp_w.size(), 0);
        chk("R4 fifo holds four words", mq.size(), 4);
        chk("R7 second done pulse", done_cnt, 2);

        // Receive pause at almost-full (R5)
        sb_tag = "R5";
        rx_gap = 0;
        af_level = 5'd1;
        wr_len(7);
        wr_cnt(0);
        kick(1'b1, 1'b1);
        gen_rx(8, 1, 8'h31);
        repeat (8) tick();
        chk("R5 rx held above level: bytes left at source", src.size(), 4);
        chk("R5 rx held: byte_left", byte_left, 4);
        chk("R5 rx_ready low with data offered", int'(rx_ready), 0);
        host_drain = 1;
        run_out("R5");
        host_drain = 0;
        chk("R5 remaining words pushed", exp_w.size(), 0);
        chk("R7 third done pulse", done_cnt, 3);
        af_level = 5'd31;
        rx_en = 0;

        // Odd transmit, 2 blocks x 3 bytes, with stall (R4, R5, R6, R10)
        sb_tag = "R4";
        wr_len(2);
        wr_cnt(1);
        kick(1'b1, 1'b0);
        tick();
        chk("R5 no tx offer with empty fifo", int'(tx_valid), 0);
        chk("R5 byte_left unchanged while empty", byte_left, 3);
        mq.push_back(16'h4241); mq.push_back(16'hEE43);
        mq.push_back(16'h4544); mq.push_back(16'hEE46);
        exp_b = '{8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h46};
        tx_en = 1;
        tick();
        chk("R6 byte_left after one byte", byte_left, 2);
        tick();
        chk("R10 one byte per clock", byte_left, 1);
        tx_en = 0;
        repeat (3) tick();
        chk("R10 stall holds byte_left", byte_left, 1);
        chk("R10 stall holds fifo", mq.size(), 3);
        tx_en = 1;
        tick();
        chk("R6 block end reload byte_left", byte_left, 3);
        chk("R6 block end blk_left", blk_left, 1);
        run_out("R4");
        chk("R4 all tx bytes sent", exp_b.size(), 0);
        chk("R4 high byte of odd word dropped", mq.size(), 0);
        chk("R7 fourth done pulse", done_cnt, 4);

        // Abort by non-data command, then count write reload (R8, R9, R2)
        sb_tag = "R8";
        wr_len(7);
        wr_cnt(0);
        kick(1'b1, 1'b0);
        for (int i = 0; i < 4; i++) mq.push_back(16'h5150 + 16'(i * 16'h0202));
        exp_b = '{8'h50, 8'h51, 8'h52};
        tick(); tick(); tick();
        chk("R9 live byte_left mid block", byte_left, 5);
        kick(1'b0, 1'b0);
        chk("R8 non-data start halts", xfer_active, 0);
        tick(); tick();
        chk("R8 no offer after halt", int'(tx_valid), 0);
        chk("R8 byte_left frozen after halt", byte_left, 5);
        chk("R8 no done on abort", done_cnt, 4);
        wr_cnt(0);
        chk("R2 count write reloads byte counter", byte_left, 8);
        chk("R2 count write blk_left", blk_left, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule